// File: doc/BRIEF.md
# Serial EEPROM status word and busy reporting unit

This unit sits beside the command decoder of a serial EEPROM. It assembles the 8-bit status word and shifts it out, one bit per clock and most significant bit first, when a read-status command is taken. The word opens with a fixed 1-0-1 signature. The device stays silent while it is in an error state, so a host that sees the signature knows the device is listening, even if a program or erase cycle is running. The unit also owns the self-timed program/erase cycle. The cycle length is a parameter in clock cycles. During the cycle the unit can drive a ready/busy level on the data output. The level is low while busy. It goes high when the cycle ends and stays high until the next opcode arrives.

A guard sits in front of the two whole-array commands. A clear-all runs only when a second clear-all follows at once. A write-all runs only when it follows a clear-all directly. Every cell write is issued to the array as an erase strobe (cells to all ones) followed by a program strobe. Errors are reported by the decoder as parity or instruction error pulses. Chip select low clears the error state but does not clear the recorded error bits. Those bits are cleared only once a full status word has been sent.

Top module: `nvm_status_busy`

## Requirements
- R1: During and right after reset, do_oe_o, busy_o, arr_erase_o, arr_prog_o and arr_all_o are 0, and busy indication is disabled.
- R2: A command accepted with cmd_i = 1 (read status) drives do_oe_o = 1 for the 8 following cycles. In those cycles do_o shows, in order: 1, 0, 1, parity-error record, instruction-error record, busy, 0, 0. The busy bit is the value of busy_o in the cycle the command is taken.
- R3: A command accepted while idle with cmd_i = 2 (write cell) or cmd_i = 3 (erase cell) makes busy_o high for exactly PE_CYCLES cycles, starting in the next cycle. Start commands that arrive while busy_o is high are ignored.
- R4: arr_erase_o pulses in the first busy cycle of every operation. arr_prog_o pulses in busy cycle PE_CYCLES/2 (counting from 0), and only for write cell and write-all. arr_all_o is high through every cycle of a whole-array operation.
- R5: With busy indication on (cmd_i = 6 sets it), do_oe_o = 1 and do_o = 0 for every busy cycle. Afterwards do_o = 1 with do_oe_o = 1 until an opcode is accepted after the cycle has ended. A command taken in the last busy cycle does not end the ready level.
- R6: With busy indication off (cmd_i = 7 clears it), do_oe_o stays 0 through program/erase cycles.
- R7: par_err_i or ins_err_i high while cs_i is high puts the unit into an error state from the next cycle. In that state do_oe_o = 0 and every command, read status included, is ignored.
- R8: The error state ends when cs_i goes low. The recorded error bits survive that and are cleared after a full status word has been shifted out.
- R9: cs_i low forces do_oe_o = 0 in the same cycle, aborts a status shift and clears a pending clear-all. It leaves a running cycle and the busy indication setting unchanged.
- R10: Clear-all (cmd_i = 4) starts an erase of the whole array only when it directly follows another accepted clear-all. A single clear-all only arms the guard.
- R11: Write-all (cmd_i = 5) starts only when it directly follows an arming clear-all. Any other accepted command in between disarms the guard.
- R12: A read status taken in the last busy cycle reports busy = 1. After the word ends, the ready level (do_o = 1) resumes if busy indication is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| cmd_valid_i | input | 1 | A decoded opcode is presented this cycle |
| cmd_i | input | 4 | Decoded opcode code |
| par_err_i | input | 1 | Parity error pulse from the decoder |
| ins_err_i | input | 1 | Instruction error pulse from the decoder |
| do_o | output | 1 | Serial data output level |
| do_oe_o | output | 1 | Output enable for do_o (0 = high impedance) |
| busy_o | output | 1 | Program/erase cycle in progress |
| arr_erase_o | output | 1 | One-cycle erase strobe to the array |
| arr_prog_o | output | 1 | One-cycle program strobe to the array |
| arr_all_o | output | 1 | Current operation covers the whole array |

## Verification
Two events can land in the same cycle: the timer finishing its last busy cycle, and a read-status opcode being accepted. The bench issues the read status exactly in the last busy cycle. It then checks that the busy bit in the returned word is 1, and that the ready level, not high impedance, follows the word. A second collision is chip select dropping in the middle of a status shift. The bench requires the output to go idle in that same cycle and to stay idle after chip select returns.

// File: rtl/nvm_sb_pkg.sv
`timescale 1ns/1ps
package nvm_sb_pkg;

  localparam int STAT_W = 8;

  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_STAT    = 4'd1,
    CMD_PROG    = 4'd2,
    CMD_CLR     = 4'd3,
    CMD_CLRALL  = 4'd4,
    CMD_PROGALL = 4'd5,
    CMD_BUSYON  = 4'd6,
    CMD_BUSYOFF = 4'd7,
    CMD_RD      = 4'd8,
    CMD_OTHER   = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    OP_CLR1    = 2'd0,
    OP_PROG1   = 2'd1,
    OP_CLRALL  = 2'd2,
    OP_PROGALL = 2'd3
  } pe_op_e;

endpackage

// File: rtl/nvm_sb_pe_timer.sv
`timescale 1ns/1ps
module nvm_sb_pe_timer
  import nvm_sb_pkg::*;
#(
  parameter int PE_CYCLES = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  pe_op_e op_i,
  output logic   busy_o,
  output logic   done_o,
  output logic   erase_stb_o,
  output logic   prog_stb_o,
  output logic   all_o
);

  localparam int CNT_W = ($clog2(PE_CYCLES) < 1) ? 1 : $clog2(PE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PE_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(PE_CYCLES - 1 - PE_CYCLES / 2);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  pe_op_e           op_q, op_d;
  logic             upd;

  assign upd = busy_q | start_i;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
      op_d   = op_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_CLR1;
    end else if (upd) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = busy_q && (cnt_q == '0);
  assign erase_stb_o = busy_q && (cnt_q == CNT_LOAD);
  assign prog_stb_o  = busy_q && (cnt_q == CNT_MID) &&
                       ((op_q == OP_PROG1) || (op_q == OP_PROGALL));
  assign all_o       = busy_q && ((op_q == OP_CLRALL) || (op_q == OP_PROGALL));

endmodule

// File: rtl/nvm_sb_bulk_guard.sv
`timescale 1ns/1ps
module nvm_sb_bulk_guard
  import nvm_sb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic acc_i,
  input  cmd_e cmd_i,
  output logic clrall_go_o,
  output logic progall_go_o
);

  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (!cs_i)      armed_d = 1'b0;
    else if (acc_i) armed_d = (cmd_i == CMD_CLRALL) && !armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign clrall_go_o  = acc_i && armed_q && (cmd_i == CMD_CLRALL);
  assign progall_go_o = acc_i && armed_q && (cmd_i == CMD_PROGALL);

endmodule

// File: rtl/nvm_sb_stat_shift.sv
`timescale 1ns/1ps
module nvm_sb_stat_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              active_o,
  output logic              bit_o,
  output logic              done_o
);

  localparam int BC_W = ($clog2(WORD_W) < 1) ? 1 : $clog2(WORD_W);
  localparam logic [BC_W-1:0] BC_LOAD = BC_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic              act_q, act_d;

  always_comb begin
    sh_d  = sh_q;
    bc_d  = bc_q;
    act_d = act_q;
    if (!run_i) begin
      act_d = 1'b0;
    end else if (load_i) begin
      act_d = 1'b1;
      sh_d  = word_i;
      bc_d  = BC_LOAD;
    end else if (act_q) begin
      sh_d = {sh_q[WORD_W-2:0], 1'b0};
      if (bc_q == '0) act_d = 1'b0;
      else            bc_d  = bc_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bc_q  <= '0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      bc_q  <= bc_d;
      act_q <= act_d;
    end
  end

  assign active_o = act_q;
  assign bit_o    = sh_q[WORD_W-1];
  assign done_o   = run_i && act_q && (bc_q == '0);

endmodule

// File: rtl/nvm_status_busy.sv
`timescale 1ns/1ps
module nvm_status_busy
  import nvm_sb_pkg::*;
#(
  parameter int PE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_i,
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_i,
  input  logic       par_err_i,
  input  logic       ins_err_i,
  output logic       do_o,
  output logic       do_oe_o,
  output logic       busy_o,
  output logic       arr_erase_o,
  output logic       arr_prog_o,
  output logic       arr_all_o
);

  cmd_e   cmd;
  logic   err_in, acc;
  logic   err_act_q, err_act_d;
  logic   rec_par_q, rec_par_d;
  logic   rec_ins_q, rec_ins_d;
  logic   bsy_en_q, bsy_en_d;
  logic   rdy_q, rdy_d;
  logic   clrall_go, progall_go;
  logic   pe_start;
  pe_op_e pe_op;
  logic   busy, pe_done;
  logic   run, stat_load;
  logic   shift_act, shift_bit, shift_done;
  logic [STAT_W-1:0] stat_word;

  assign cmd    = cmd_e'(cmd_i);
  assign err_in = par_err_i | ins_err_i;
  assign acc    = cmd_valid_i & cs_i & ~err_act_q & ~err_in;
  assign run    = cs_i & ~err_act_q;

  nvm_sb_bulk_guard u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_i         (cs_i),
    .acc_i        (acc),
    .cmd_i        (cmd),
    .clrall_go_o  (clrall_go),
    .progall_go_o (progall_go)
  );

  always_comb begin
    pe_start = 1'b0;
    pe_op    = OP_CLR1;
    if (!busy) begin
      if (progall_go) begin
        pe_start = 1'b1;
        pe_op    = OP_PROGALL;
      end else if (clrall_go) begin
        pe_start = 1'b1;
        pe_op    = OP_CLRALL;
      end else if (acc && (cmd == CMD_PROG)) begin
        pe_start = 1'b1;
        pe_op    = OP_PROG1;
      end else if (acc && (cmd == CMD_CLR)) begin
        pe_start = 1'b1;
        pe_op    = OP_CLR1;
      end
    end
  end

  nvm_sb_pe_timer #(.PE_CYCLES(PE_CYCLES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (pe_start),
    .op_i        (pe_op),
    .busy_o      (busy),
    .done_o      (pe_done),
    .erase_stb_o (arr_erase_o),
    .prog_stb_o  (arr_prog_o),
    .all_o       (arr_all_o)
  );

  // signature 1-0-1, error records, busy, two reserved zeros
  assign stat_word = {3'b101, rec_par_q, rec_ins_q, busy, 2'b00};
  assign stat_load = acc && (cmd == CMD_STAT);

  nvm_sb_stat_shift #(.WORD_W(STAT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .load_i   (stat_load),
    .word_i   (stat_word),
    .active_o (shift_act),
    .bit_o    (shift_bit),
    .done_o   (shift_done)
  );

  always_comb begin
    err_act_d = err_act_q;
    if (!cs_i)       err_act_d = 1'b0;
    else if (err_in) err_act_d = 1'b1;

    rec_par_d = rec_par_q;
    if (cs_i && par_err_i) rec_par_d = 1'b1;
    else if (shift_done)   rec_par_d = 1'b0;

    rec_ins_d = rec_ins_q;
    if (cs_i && ins_err_i) rec_ins_d = 1'b1;
    else if (shift_done)   rec_ins_d = 1'b0;

    bsy_en_d = bsy_en_q;
    if (acc && (cmd == CMD_BUSYON))       bsy_en_d = 1'b1;
    else if (acc && (cmd == CMD_BUSYOFF)) bsy_en_d = 1'b0;

    // end of cycle wins over an opcode taken in the same cycle
    rdy_d = rdy_q;
    if (!cs_i)                    rdy_d = 1'b0;
    else if (pe_done && bsy_en_q) rdy_d = 1'b1;
    else if (acc)                 rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_act_q <= 1'b0;
      rec_par_q <= 1'b0;
      rec_ins_q <= 1'b0;
      bsy_en_q  <= 1'b0;
      rdy_q     <= 1'b0;
    end else begin
      err_act_q <= err_act_d;
      rec_par_q <= rec_par_d;
      rec_ins_q <= rec_ins_d;
      bsy_en_q  <= bsy_en_d;
      rdy_q     <= rdy_d;
    end
  end

  assign busy_o  = busy;
  assign do_oe_o = run && (shift_act || (bsy_en_q && (busy || rdy_q)));
  assign do_o    = shift_act ? shift_bit : ~busy;

endmodule

// File: rtl/nvm_status_busy_chk.sv
`timescale 1ns/1ps
module nvm_status_busy_chk
  import nvm_sb_pkg::*;
#(
  parameter int PE_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_i,
  input logic       cmd_valid_i,
  input logic [3:0] cmd_i,
  input logic       par_err_i,
  input logic       ins_err_i,
  input logic       do_o,
  input logic       do_oe_o,
  input logic       busy_o,
  input logic       arr_erase_o,
  input logic       arr_prog_o,
  input logic       arr_all_o,
  input logic       shift_act,
  input logic       bsy_en_q,
  input logic       err_act_q
);

  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_cnt == PE_CYCLES));

  a_r4_erase_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> arr_erase_o);

  a_r4_strobe_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_erase_o || arr_prog_o) |-> (busy_o && !(arr_erase_o && arr_prog_o)));

  a_r5_busy_level: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && bsy_en_q && cs_i && !err_act_q && !shift_act) |-> (do_oe_o && !do_o));

  a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && $past(cs_i) && $past(par_err_i || ins_err_i)) |-> !do_oe_o);

  a_r9_cs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |-> !do_oe_o);

  a_r10_bulk_origin: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && arr_all_o) |->
      $past(cmd_valid_i && ((cmd_i == CMD_CLRALL) || (cmd_i == CMD_PROGALL))));

endmodule

bind nvm_status_busy nvm_status_busy_chk #(.PE_CYCLES(PE_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_i        (cs_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .par_err_i   (par_err_i),
  .ins_err_i   (ins_err_i),
  .do_o        (do_o),
  .do_oe_o     (do_oe_o),
  .busy_o      (busy_o),
  .arr_erase_o (arr_erase_o),
  .arr_prog_o  (arr_prog_o),
  .arr_all_o   (arr_all_o),
  .shift_act   (shift_act),
  .bsy_en_q    (bsy_en_q),
  .err_act_q   (err_act_q)
);

// File: tb/nvm_status_busy_tb_top.sv
`timescale 1ns/1ps
module nvm_status_busy_tb_top;
  import nvm_sb_pkg::*;

  localparam int P = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs;
  logic       cmd_valid;
  logic [3:0] cmd;
  logic       par_err, ins_err;
  logic       do_o, do_oe, busy, arr_erase, arr_prog, arr_all;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  nvm_status_busy #(.PE_CYCLES(P)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_i        (cs),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .par_err_i   (par_err),
    .ins_err_i   (ins_err),
    .do_o        (do_o),
    .do_oe_o     (do_oe),
    .busy_o      (busy),
    .arr_erase_o (arr_erase),
    .arr_prog_o  (arr_prog),
    .arr_all_o   (arr_all)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send(cmd_e c);
    cmd_valid = 1'b1;
    cmd       = c;
    step();
    cmd_valid = 1'b0;
    cmd       = CMD_NOP;
  endtask

  task automatic read_word(output logic [7:0] w, output int oe_n);
    w    = '0;
    oe_n = 0;
    send(CMD_STAT);
    for (int i = 0; i < 8; i++) begin
      w = {w[6:0], do_o};
      if (do_oe) oe_n++;
      step();
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * P && busy; i++) step();
    step();
  endtask

  task automatic err_pulse(logic p, logic s);
    par_err = p;
    ins_err = s;
    step();
    par_err = 1'b0;
    ins_err = 1'b0;
  endtask

  task automatic cs_pulse();
    cs = 1'b0;
    step();
    cs = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    logic [7:0] w;
    int         oe_n;
    int         cnt;
    rst_n = 1'b0; cs = 1'b1; cmd_valid = 1'b0; cmd = CMD_NOP;
    par_err = 1'b0; ins_err = 1'b0;
    repeat (3) step();
    chk("R1 oe in reset", do_oe, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    step();
    chk("R1 oe", do_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {arr_erase, arr_prog, arr_all}, 0);

    // R2 / R8: sweep every combination of the three variable status bits
    for (int code = 0; code < 8; code++) begin
      logic p, s, b;
      p = code[2]; s = code[1]; b = code[0];
      if (b) send(CMD_PROG);
      if (p || s) begin
        err_pulse(p, s);
        cs_pulse();
      end
      read_word(w, oe_n);
      chk($sformatf("R2 word code %0d", code), w, {3'b101, p, s, b, 2'b00});
      chk("R2 oe count", oe_n, 8);
      read_word(w, oe_n);
      chk("R8 records cleared after word", w, 8'hA0);
      wait_idle();
    end

    // R3 / R4 / R10 / R11: each operation kind, cycle by cycle
    for (int op = 0; op < 4; op++) begin
      logic wr, al;
      wr = (op == 0) || (op == 3);
      al = (op >= 2);
      case (op)
        0: send(CMD_PROG);
        1: send(CMD_CLR);
        2: begin send(CMD_CLRALL); chk("R10 single clear-all idle", busy, 0); send(CMD_CLRALL); end
        default: begin send(CMD_CLRALL); send(CMD_PROGALL); end
      endcase
      for (int k = 0; k < P; k++) begin
        chk($sformatf("R3 busy op%0d k%0d", op, k), busy, 1);
        chk($sformatf("R4 erase op%0d k%0d", op, k), arr_erase, (k == 0));
        chk($sformatf("R4 prog op%0d k%0d", op, k), arr_prog, (wr && k == P / 2));
        chk($sformatf("R11 all op%0d k%0d", op, k), arr_all, al);
        step();
      end
      chk("R3 busy ends", busy, 0);
      step();
    end

    // R3: start while busy is ignored
    send(CMD_PROG);
    cnt = 1;
    send(CMD_CLR);
    for (int i = 0; i < 3 * P && busy; i++) begin cnt++; step(); end
    chk("R3 busy length with extra start", cnt, P);
    step();
    chk("R3 no second cycle", busy, 0);

    // R11 / R9 negative sequences
    send(CMD_PROGALL);
    chk("R11 lone write-all", busy, 0);
    send(CMD_CLRALL); send(CMD_NOP); send(CMD_PROGALL);
    chk("R11 write-all after gap", busy, 0);
    send(CMD_CLRALL); cs_pulse(); send(CMD_CLRALL);
    chk("R9 cs low disarms clear-all", busy, 0);
    send(CMD_NOP);

    // R5: ready/busy level
    send(CMD_BUSYON);
    send(CMD_PROG);
    for (int k = 0; k < P; k++) begin
      chk("R5 busy oe", do_oe, 1);
      chk("R5 busy low", do_o, 0);
      step();
    end
    for (int k = 0; k < 3; k++) begin
      chk("R5 ready oe", do_oe, 1);
      chk("R5 ready high", do_o, 1);
      step();
    end
    send(CMD_NOP);
    chk("R5 released by opcode", do_oe, 0);

    // R12: read status in the last busy cycle
    send(CMD_PROG);
    repeat (P - 1) step();
    read_word(w, oe_n);
    chk("R12 word", w, 8'hA4);
    chk("R12 oe count", oe_n, 8);
    chk("R12 ready resumes oe", do_oe, 1);
    chk("R12 ready resumes level", do_o, 1);
    send(CMD_RD);
    chk("R12 released", do_oe, 0);

    // R9: busy indication setting survives chip select
    cs_pulse();
    send(CMD_PROG);
    chk("R9 enable kept oe", do_oe, 1);
    chk("R9 enable kept level", do_o, 0);
    wait_idle();
    send(CMD_NOP);

    // R6: indication disabled
    send(CMD_BUSYOFF);
    send(CMD_CLR);
    for (int k = 0; k < P; k++) begin
      chk("R6 quiet during cycle", do_oe, 0);
      step();
    end
    chk("R6 quiet after cycle", do_oe, 0);
    wait_idle();

    // R7 / R8: error state
    err_pulse(1'b1, 1'b0);
    chk("R7 oe in error", do_oe, 0);
    read_word(w, oe_n);
    chk("R7 status ignored", oe_n, 0);
    send(CMD_PROG);
    chk("R7 start ignored", busy, 0);
    cs_pulse();
    read_word(w, oe_n);
    chk("R8 record kept over cs", w, 8'hB0);
    chk("R8 answers after cs", oe_n, 8);

    // R9: chip select low aborts a shift
    send(CMD_STAT);
    step(); step();
    cs = 1'b0;
    #1;
    chk("R9 oe same cycle", do_oe, 0);
    step();
    cs = 1'b1;
    #1;
    chk("R9 shift aborted", do_oe, 0);
    step();
    chk("R9 still idle", do_oe, 0);

    report();
  end

endmodule